// File: doc/BRIEF.md
# Current-Source Converter Gate Modulator

This block converts two signed duty commands into six gate signals for a single-phase current-source converter that has a series voltage buffer leg. The rectifier command `dr_cmd` sets the share of each switching period in which the DC inductor current is steered into the line. The buffer command `dd_cmd` sets how long the buffer capacitor is inserted in series with the DC inductor. Gates 1 to 4 drive the bridge. Gates 5 and 6 drive the buffer leg.

A symmetric up/down carrier sets the switching period. The period is 2·HALF clocks, which is 20 kHz at the default clock. At the start of each period the block samples both commands, the grid sign and the enable. It limits the command magnitudes so that no pulse becomes too narrow. It then selects, for each switch, whether the switch is held on, held off, pulsed centred on the carrier peak, or pulsed centred on the carrier valley. Bridge gates that commutate against each other share one compare level, so they are exact complements before overlap is added.

Each gate's turn-off is stretched by a programmable number of clocks. The incoming switch therefore always conducts before the outgoing switch releases, and the inductor current always has a path.

Top module: `csc_gate_mod`

## Requirements
- R1: During and after reset, before the first period boundary, the gates are in the bypass state: `sw_on` = 6'b010011 (bit i drives switch i+1, and 1 means conducting).
- R2: With `ug_pos`=1 and enable high, switch 1 is held on and switch 3 is held off. Switch 4 conducts for the fraction dr of the period, centred on the carrier peak. Switch 2 conducts for the rest of the period.
- R3: With `ug_pos`=0 and enable high, switch 3 is held on and switch 1 is held off. Switch 2 conducts for the fraction −dr, centred on the carrier peak. Switch 4 conducts for the rest of the period.
- R4: If dd ≥ 0, switch 6 is held off and switch 5 conducts for 1−|dd|, centred on the valley. If dd < 0, switch 6 is held on and switch 5 conducts for |dd|, centred on the peak.
- R5: Commands are signed Q1.15: 16-bit two's complement, where 32768 counts as 1.0 and −32768 as −1.0. Before mapping, each command magnitude is limited to [EPS, 32768−EPS]. A zero command counts as positive.
- R6: If the sign of dr is opposite to the grid sign, the active bridge fraction becomes zero. The active switch stays off and its partner is on for the whole period.
- R7: The period is 2·HALF clocks. A fraction m gives T = floor(m·HALF/32768) and a peak-centred pulse of 2T clocks. The complementary switch is on for 2·(HALF−T) clocks. A gate output rises one clock after its compare goes true.
- R8: Every falling gate edge is delayed by `ovl_len` clocks. At every cycle, at least one of switches 1 and 3 and at least one of switches 2 and 4 conducts.
- R9: Changes of `ug_pos`, `dr_cmd` and `dd_cmd` take effect only at the next period boundary. No gate output changes mid-period because of them.
- R10: When enable is sampled low at a boundary, the next period uses the bypass state: switches 1, 2 and 5 are on, and switches 3, 4 and 6 are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Modulation enable; low selects bypass |
| ug_pos | input | 1 | Grid voltage sign, 1 = positive |
| dr_cmd | input | DW | Rectifier duty command, signed Q1.15 |
| dd_cmd | input | DW | Buffer duty command, signed Q1.15 |
| ovl_len | input | OW | Overlap length in clocks |
| sw_on | output | 6 | Gate outputs; bit i drives switch i+1 |

## Verification
The bench goes after the clamp limits at zero and full-scale commands. If the limit were missing, a sliver pulse of a few clocks would appear, or a gate would sit stuck on for the whole period. It drives commands whose sign is opposite to the grid sign; a design without saturation would invert the bridge roles. It measures the cycles in which switches 2 and 4 conduct together, which catches missing or doubled overlap and complementary pairs that drift apart by one count. It changes the grid sign mid-period and checks that switch 1 falls only one clock after the boundary that the pulse position implies, and that the pulse sits centred on the carrier peak.

// File: rtl/csc_mod_pkg.sv
package csc_mod_pkg;
   // per-gate waveform selection
   typedef enum logic [1:0] {
      GM_OFF    = 2'd0,
      GM_ON     = 2'd1,
      GM_PEAK   = 2'd2,   // on while cnt >= level
      GM_VALLEY = 2'd3    // on while cnt <  level
   } gmode_t;

   localparam int NGATE = 6;
   // bypass pattern: switches 1, 2, 5 on
   localparam logic [NGATE-1:0] BYPASS_PAT = 6'b010011;
endpackage

// File: rtl/csc_carrier.sv
module csc_carrier #(
   parameter int HALF = 1250,
   parameter int CW   = $clog2(HALF + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [CW-1:0] cnt,
   output logic          load
);
   logic dn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         dn  <= 1'b0;
      end else if (!dn) begin
         if (cnt == CW'(HALF - 1)) dn <= 1'b1;
         else                      cnt <= cnt + 1'b1;
      end else begin
         if (cnt == '0) dn <= 1'b0;
         else           cnt <= cnt - 1'b1;
      end
   end

   // last cycle of the period: the next cycle starts a fresh up-count
   assign load = dn && (cnt == '0);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt < CW'(HALF)); // R7
   AST_VALLEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n) load |=> (cnt == '0) && !load); // R7
endmodule

// File: rtl/csc_duty_map.sv
module csc_duty_map
   import csc_mod_pkg::*;
#(
   parameter int DW   = 16,
   parameter int HALF = 1250,
   parameter int CW   = $clog2(HALF + 1),
   parameter int EPS  = 328
) (
   input  logic          en,
   input  logic          ug_pos,
   input  logic [DW-1:0] dr_cmd,
   input  logic [DW-1:0] dd_cmd,
   output gmode_t        mode [NGATE],
   output logic [CW-1:0] lvl  [NGATE]
);
   localparam logic [DW-1:0] LO = DW'(EPS);
   localparam logic [DW-1:0] HI = DW'((1 << (DW - 1)) - EPS);

   function automatic logic [DW-1:0] clamp_mag(input logic [DW-1:0] x);
      logic [DW-1:0] m;
      m = x[DW-1] ? (~x + 1'b1) : x;
      if (m < LO)      m = LO;
      else if (m > HI) m = HI;
      return m;
   endfunction

   // compare level: HALF - floor(m * HALF / 2^(DW-1))
   function automatic logic [CW-1:0] level_of(input logic [DW-1:0] m);
      return CW'(HALF) - CW'(((DW+CW)'(m) * (DW+CW)'(HALF)) >> (DW - 1));
   endfunction

   logic [DW-1:0] act_r, mag_d;
   logic [CW-1:0] lv_r, lv_d;

   always_comb begin
      act_r = (ug_pos != dr_cmd[DW-1]) ? clamp_mag(dr_cmd) : '0;
      mag_d = clamp_mag(dd_cmd);
      lv_r  = level_of(act_r);
      lv_d  = level_of(mag_d);

      for (int i = 0; i < NGATE; i++) lvl[i] = '0;
      mode[0] = GM_ON;  mode[1] = GM_ON;
      mode[2] = GM_OFF; mode[3] = GM_OFF;
      mode[4] = GM_ON;  mode[5] = GM_OFF;

      if (en) begin
         lvl[1] = lv_r;
         lvl[3] = lv_r;
         if (ug_pos) begin
            mode[0] = GM_ON;     mode[2] = GM_OFF;
            mode[3] = GM_PEAK;   mode[1] = GM_VALLEY;
         end else begin
            mode[0] = GM_OFF;    mode[2] = GM_ON;
            mode[1] = GM_PEAK;   mode[3] = GM_VALLEY;
         end
         lvl[4] = lv_d;
         if (dd_cmd[DW-1]) begin
            mode[4] = GM_PEAK;   mode[5] = GM_ON;
         end else begin
            mode[4] = GM_VALLEY; mode[5] = GM_OFF;
         end
      end
   end
endmodule

// File: rtl/csc_gate_drv.sv
module csc_gate_drv
   import csc_mod_pkg::*;
#(
   parameter int CW     = 11,
   parameter int OW     = 6,
   parameter bit RST_ON = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  gmode_t        mode_in,
   input  logic [CW-1:0] lvl_in,
   input  logic [CW-1:0] cnt,
   input  logic [OW-1:0] ovl_len,
   output logic          sw
);
   gmode_t        mode_q;
   logic [CW-1:0] lvl_q;
   logic [OW-1:0] hold;
   logic          raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RST_ON ? GM_ON : GM_OFF;
         lvl_q  <= '0;
      end else if (load) begin
         mode_q <= mode_in;
         lvl_q  <= lvl_in;
      end
   end

   always_comb begin
      case (mode_q)
         GM_ON:     raw = 1'b1;
         GM_PEAK:   raw = (cnt >= lvl_q);
         GM_VALLEY: raw = (cnt < lvl_q);
         default:   raw = 1'b0;
      endcase
   end

   // turn-off delay: the gate stays on for ovl_len clocks after compare drops
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw   <= RST_ON;
         hold <= '0;
      end else if (raw) begin
         sw   <= 1'b1;
         hold <= ovl_len;
      end else if (hold != '0) begin
         sw   <= 1'b1;
         hold <= hold - 1'b1;
      end else begin
         sw   <= 1'b0;
      end
   end

   AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) raw |=> sw); // R7
   AST_OVL_STRETCH: assert property (@(posedge clk) disable iff (!rst_n) (!raw && $past(raw) && ovl_len != '0 && $stable(ovl_len)) |=> sw); // R8
   AST_MODE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mode_q) |-> $past(load)); // R9
endmodule

// File: rtl/csc_gate_mod.sv
module csc_gate_mod
   import csc_mod_pkg::*;
#(
   parameter int DW   = 16,
   parameter int HALF = 1250,
   parameter int EPS  = 328,
   parameter int OW   = 6,
   localparam int CW  = $clog2(HALF + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          ug_pos,
   input  logic [DW-1:0] dr_cmd,
   input  logic [DW-1:0] dd_cmd,
   input  logic [OW-1:0] ovl_len,
   output logic [5:0]    sw_on
);
   generate
      if (HALF < 2) begin : g_bad_half
         $error("HALF must be at least 2");
      end
      if (EPS < 1 || EPS >= (1 << (DW - 2))) begin : g_bad_eps
         $error("EPS must lie in [1, quarter scale)");
      end
      if (DW < 4 || OW < 1) begin : g_bad_width
         $error("DW or OW too small");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          load;
   gmode_t        gm [NGATE];
   logic [CW-1:0] gl [NGATE];

   csc_carrier #(.HALF(HALF), .CW(CW)) u_car (
      .clk(clk), .rst_n(rst_n), .cnt(cnt), .load(load)
   );

   csc_duty_map #(.DW(DW), .HALF(HALF), .CW(CW), .EPS(EPS)) u_map (
      .en(en), .ug_pos(ug_pos), .dr_cmd(dr_cmd), .dd_cmd(dd_cmd),
      .mode(gm), .lvl(gl)
   );

   for (genvar g = 0; g < NGATE; g++) begin : g_gate
      csc_gate_drv #(.CW(CW), .OW(OW), .RST_ON(BYPASS_PAT[g])) u_drv (
         .clk(clk), .rst_n(rst_n), .load(load),
         .mode_in(gm[g]), .lvl_in(gl[g]), .cnt(cnt),
         .ovl_len(ovl_len), .sw(sw_on[g])
      );
   end

   AST_BRIDGE_PATH: assert property (@(posedge clk) disable iff (!rst_n) (sw_on[0] | sw_on[2]) && (sw_on[1] | sw_on[3])); // R8
endmodule

// File: tb/sim_csc_gate_mod.sv
module sim_csc_gate_mod;
   localparam int HALF = 100;
   localparam int PER  = 2 * HALF;
   localparam int NV   = 7;
   // en, ug, dr, dd, ovl, s1..s6 on-cycles per period, s2&s4 both-on cycles
   localparam int VEC [NV][12] = '{
      '{1, 1,   8192,  16384, 0, 200, 150,   0,  50, 100,   0, 0},
      '{1, 0,  -8192,  -8192, 3,   0,  53, 200, 153,  53, 200, 6},
      '{1, 1,      0,    100, 0, 200, 192,   0,   8, 192,   0, 0},
      '{1, 0, -32768,  32767, 2,   0, 192, 200,  12,  12,   0, 4},
      '{1, 1, -16384, -16384, 1, 200, 200,   0,   0, 101, 200, 0},
      '{0, 0,   8192, -16384, 4, 200, 200,   0,   0, 200,   0, 0},
      '{1, 0,   8192,  24576, 0,   0,   0, 200, 200,  50,   0, 0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0, ug_pos = 1'b1;
   logic [15:0] dr_cmd = '0, dd_cmd = '0;
   logic [3:0]  ovl_len = '0;
   logic [5:0]  sw_on;
   int          checks = 0, failures = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   csc_gate_mod #(.DW(16), .HALF(HALF), .EPS(1638), .OW(4)) u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .ug_pos(ug_pos),
      .dr_cmd(dr_cmd), .dd_cmd(dd_cmd), .ovl_len(ovl_len), .sw_on(sw_on)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic string vtag(input int v, input int g);
      if (v == 5) return "R10";
      if (g >= 4) return "R4";
      case (v)
         0: return "R2";
         1: return "R3";
         2, 3: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int cnt_on [6];
      int both;
      int seen;
      logic prev;

      // R1: bypass state under and right after reset
      repeat (4) @(negedge clk);
      for (int g = 0; g < 6; g++) chk("R1", $sformatf("reset gate%0d", g + 1), int'(sw_on[g]), int'(6'b010011 >> g) & 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "post-reset pattern", int'(sw_on), 6'b010011);

      // table walk: steady-state on-cycles per period (R7 quantisation, R8 overlap)
      for (int v = 0; v < NV; v++) begin
         en      = VEC[v][0][0];
         ug_pos  = VEC[v][1][0];
         dr_cmd  = 16'(VEC[v][2]);
         dd_cmd  = 16'(VEC[v][3]);
         ovl_len = 4'(VEC[v][4]);
         repeat (2 * PER) @(negedge clk);
         for (int g = 0; g < 6; g++) cnt_on[g] = 0;
         both = 0;
         for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            for (int g = 0; g < 6; g++) cnt_on[g] += int'(sw_on[g]);
            both += int'(sw_on[1] & sw_on[3]);
         end
         for (int g = 0; g < 6; g++)
            chk(vtag(v, g), $sformatf("vec%0d gate%0d on-cycles", v, g + 1), cnt_on[g], VEC[v][5 + g]);
         chk("R8", $sformatf("vec%0d s2/s4 overlap cycles", v), both, VEC[v][11]);
      end

      // R9 / R7: pulse centring and boundary-only update of the grid sign
      en = 1'b1; ug_pos = 1'b1; dr_cmd = 16'd8192; dd_cmd = 16'd16384; ovl_len = '0;
      repeat (2 * PER) @(negedge clk);
      seen = 0;
      prev = sw_on[3];
      for (int c = 0; c < 2 * PER && seen == 0; c++) begin
         @(negedge clk);
         if (sw_on[3] && !prev) seen = 1;
         prev = sw_on[3];
      end
      chk("R7", "found switch-4 rising edge", seen, 1);
      // now at period position 76; flip the grid sign mid-period
      ug_pos = 1'b0;
      repeat (49) @(negedge clk);
      chk("R7", "switch 4 still on at pos 125", int'(sw_on[3]), 1);
      @(negedge clk);
      chk("R7", "switch 4 off at pos 126", int'(sw_on[3]), 0);
      repeat (74) @(negedge clk);
      chk("R9", "switch 1 held until boundary", int'(sw_on[0]), 1);
      chk("R9", "switch 3 held off until boundary", int'(sw_on[2]), 0);
      @(negedge clk);
      chk("R9", "switch 1 off after boundary", int'(sw_on[0]), 0);
      chk("R9", "switch 3 on after boundary", int'(sw_on[2]), 1);

      finish_up();
   end
endmodule